// File: doc/BRIEF.md
# Coprocessor Module Control and Status Register

This block is the host-facing control and status word of a coprocessor with two execution engines and a shared code memory. It collects sticky exception flags from the engines, reports the code-memory size, holds the enable bit and mismatch flag of the code-memory signature checker, and holds a visibility bit. The visibility bit decides whether the host may reach the code memory over the register bus at all. The block itself stores no code memory. It answers register reads and writes in the same cycle, and for code-memory accesses it either grants them (`cm_access_ok`) or answers them with a bus error.

All sticky flags are cleared together by writing 1 to a single global-clear bit. The visibility bit accepts writes only while both engines report halted or stopped. While the bit is set, it locks the module-disable bits of a neighbouring engine configuration register through `eng_cfg_lock`, and it rejects every code-memory write that is not a full, word-aligned 32-bit write. Each accepted write of 1 to the visibility bit sends a one-cycle reset pulse to the signature checker and leaves the checker's enable bit unchanged.

Two small state machines carry the state. The checker machine has three states:
- `CHK_OFF`: disabled, no mismatch pending.
- `CHK_RUN`: enabled.
- `CHK_FAULT`: mismatch latched, checker disabled.

Its transitions are:
- enable-write 1: OFF→RUN, or FAULT→RUN. This also clears the flag.
- enable-write 0: RUN→OFF.
- mismatch while running: RUN→FAULT.
- global clear: FAULT→OFF.

The visibility machine has two states, `VIS_HIDDEN` and `VIS_SHOWN`. It moves between them only on a write that is accepted while both engines are halted.

Top module: `mcs_reg`

Register word, bit 0 = LSB:

| Bit | Field | Access |
|-----|-------|--------|
| 0 | global clear | write 1, reads 0 |
| 1 | engine A exception | sticky |
| 2 | engine B exception | sticky |
| 3 | engine A illegal instruction | sticky |
| 8:4 | code-memory size | read-only |
| 12 | signature mismatch | sticky, read-only |
| 13 | checker enable | read/write |
| 16 | visibility | read/write |

All other bits are reserved. A field is written only when the byte strobe of its byte is set: byte 0 covers bits 7:0, byte 1 covers bits 15:8, and byte 2 covers bits 23:16.

## Requirements
- R1: After reset the three engine flags, the mismatch flag, the checker enable, the visibility bit and the reset pulse are all 0. A register read then returns only the size field.
- R2: A pulse on `eng_gexc[0]`, `eng_gexc[1]` or `eng_a_illegal` sets register bit 1, 2 or 3 respectively at the next edge. The bit then stays 1 until a global clear.
- R3: A register write with byte strobe 0 set and data bit 0 equal to 1 clears bits 1, 2, 3 and 12 at the next edge. Bit 0 always reads 0.
- R4: If a flag's set event and a global clear occur in the same cycle, the flag is 1 after the edge.
- R5: Bits 8:4 always read the parameter `SIZE_M1`, the number of 2 KB code-memory blocks minus one, and writes do not change them.
- R6: A register write with byte strobe 2 set loads bit 16 only when `eng_halted` is 2'b11. Otherwise the visibility bit keeps its value.
- R7: While visibility is 0, every code-memory access (`bus_space`=1) gets `bus_err`=1 and `cm_access_ok`=0 in the same cycle.
- R8: While visibility is 1, a code-memory write gets `bus_err` unless `bus_be`=4'hF and `bus_addr_lo`=0. Code-memory reads and full aligned writes get `cm_access_ok`=1 and no error.
- R9: `eng_cfg_lock` equals the visibility bit.
- R10: Every accepted write of 1 to visibility gives `sig_rst`=1 for exactly the cycle after the edge, with `sig_en` unchanged.
- R11: Writing bit 13 (strobe 1) as 1 enables the checker and clears bit 12. Writing it as 0 disables the checker. A `sig_mismatch` pulse while enabled sets bit 12 and clears the enable. A pulse while disabled is ignored.
- R12: Reserved bits read 0. A field whose byte strobe is clear is not written.
- R13: A mismatch pulse in the same cycle as an enable-write, while enabled, leaves the flag at 1 and the enable at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_req | input | 1 | access valid this cycle |
| bus_space | input | 1 | 0 = control register, 1 = code memory |
| bus_we | input | 1 | 1 = write |
| bus_be | input | 4 | byte strobes |
| bus_addr_lo | input | 2 | low address bits of the access |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | register read data, 0 when no register read |
| bus_err | output | 1 | error response for this access |
| cm_access_ok | output | 1 | code-memory access granted |
| eng_gexc | input | 2 | per-engine exception request pulse |
| eng_a_illegal | input | 1 | engine A illegal-instruction pulse |
| sig_mismatch | input | 1 | signature-checker mismatch pulse |
| eng_halted | input | 2 | per-engine halted-or-stopped status |
| vis_o | output | 1 | visibility bit |
| eng_cfg_lock | output | 1 | locks engine module-disable bits |
| sig_en | output | 1 | signature-checker enable |
| sig_rst | output | 1 | signature-checker state reset pulse |

## Verification
Two pairs of events can land on the same edge:
- a flag-set pulse and a global-clear write;
- a mismatch pulse and a write to the checker enable.

The bench forces each pair in directed cycles and then lets random traffic produce them many more times. For every collision it judges the outcome against a cycle model that gives the set event priority. The model also predicts whether a visibility write is accepted under random halt status, and therefore which code-memory accesses in the following cycles must get an error.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam int NUM_ENG    = 2;
    localparam int SIZE_W     = 5;
    localparam int B_GCLR     = 0;
    localparam int B_GEXC_A   = 1;
    localparam int B_GEXC_B   = 2;
    localparam int B_ILL_A    = 3;
    localparam int B_SIZE_LO  = 4;
    localparam int B_SIG_FLAG = 12;
    localparam int B_SIG_EN   = 13;
    localparam int B_VIS      = 16;
    localparam int NUM_FLAGS  = 3;

    typedef enum logic [1:0] {
        CHK_OFF   = 2'd0,
        CHK_RUN   = 2'd1,
        CHK_FAULT = 2'd2
    } chk_state_e;

    typedef enum logic {
        VIS_HIDDEN = 1'b0,
        VIS_SHOWN  = 1'b1
    } vis_state_e;
endpackage

// File: rtl/mcs_sticky.sv
module mcs_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr) begin
                flag_q[i] <= 1'b0;
            end
        end

        p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr) |=> flag_q[i]);
        p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flag_q[i]);
    end

    assign flags = flag_q;
endmodule

// File: rtl/mcs_sigchk.sv
module mcs_sigchk
    import mcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch,
    input  logic en_wr,
    input  logic en_val,
    input  logic gclr,
    output logic en_o,
    output logic flag_o
);
    chk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CHK_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHK_OFF: begin
                if (en_wr && en_val) begin
                    state_d = CHK_RUN;
                end
            end
            CHK_RUN: begin
                if (mismatch) begin
                    state_d = CHK_FAULT;
                end else if (en_wr && !en_val) begin
                    state_d = CHK_OFF;
                end
            end
            CHK_FAULT: begin
                if (en_wr && en_val) begin
                    state_d = CHK_RUN;
                end else if (gclr) begin
                    state_d = CHK_OFF;
                end
            end
            default: state_d = CHK_OFF;
        endcase
    end

    always_comb begin
        en_o   = 1'b0;
        flag_o = 1'b0;
        unique case (state_q)
            CHK_OFF:   begin en_o = 1'b0; flag_o = 1'b0; end
            CHK_RUN:   begin en_o = 1'b1; flag_o = 1'b0; end
            CHK_FAULT: begin en_o = 1'b0; flag_o = 1'b1; end
            default:   begin en_o = 1'b0; flag_o = 1'b0; end
        endcase
    end

    p_fault_on_mismatch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && mismatch) |=> (flag_o && !en_o));
    p_idle_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !flag_o && !en_wr) |=> !flag_o);
endmodule

// File: rtl/mcs_vis.sv
module mcs_vis
    import mcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic val,
    input  logic all_halted,
    output logic vis_o,
    output logic sig_rst_o
);
    vis_state_e state_q, state_d;
    logic       rst_pulse_q;
    logic       accept;

    assign accept = wr && all_halted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= VIS_HIDDEN;
            rst_pulse_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            rst_pulse_q <= accept && val;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VIS_HIDDEN: if (accept && val)  state_d = VIS_SHOWN;
            VIS_SHOWN:  if (accept && !val) state_d = VIS_HIDDEN;
            default:    state_d = VIS_HIDDEN;
        endcase
    end

    always_comb begin
        vis_o     = (state_q == VIS_SHOWN);
        sig_rst_o = rst_pulse_q;
    end

    p_vis_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !all_halted) |=> $stable(vis_o));
    p_rst_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sig_rst_o |-> vis_o);
endmodule

// File: rtl/mcs_decode.sv
module mcs_decode
    import mcs_pkg::*;
(
    input  logic            req,
    input  logic            space,
    input  logic            we,
    input  logic [BE_W-1:0] be,
    input  logic [1:0]      addr_lo,
    input  logic            vis,
    output logic            reg_wr,
    output logic            reg_rd,
    output logic            cm_err,
    output logic            cm_ok
);
    logic cm_acc, full_word;

    always_comb begin
        cm_acc    = req && space;
        full_word = (be == {BE_W{1'b1}}) && (addr_lo == 2'b00);
        reg_wr    = req && !space && we;
        reg_rd    = req && !space && !we;
        cm_err    = cm_acc && (!vis || (we && !full_word));
        cm_ok     = cm_acc && !cm_err;
    end
endmodule

// File: rtl/mcs_reg.sv
module mcs_reg
    import mcs_pkg::*;
#(
    parameter logic [4:0] SIZE_M1 = 5'd3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_space,
    input  logic                bus_we,
    input  logic [3:0]          bus_be,
    input  logic [1:0]          bus_addr_lo,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_err,
    output logic                cm_access_ok,
    input  logic [1:0]          eng_gexc,
    input  logic                eng_a_illegal,
    input  logic                sig_mismatch,
    input  logic [1:0]          eng_halted,
    output logic                vis_o,
    output logic                eng_cfg_lock,
    output logic                sig_en,
    output logic                sig_rst
);
    logic                 reg_wr, reg_rd, cm_err, cm_ok;
    logic                 gclr, en_wr, vis_wr;
    logic [NUM_FLAGS-1:0] flag_set, flags;
    logic                 sig_flag, vis_q;
    logic [DATA_W-1:0]    image;
    logic                 wdata_unused;

    assign wdata_unused = ^{bus_wdata[31:17], bus_wdata[15:14], bus_wdata[12:1]};

    mcs_decode i_decode (
        .req     (bus_req),
        .space   (bus_space),
        .we      (bus_we),
        .be      (bus_be),
        .addr_lo (bus_addr_lo),
        .vis     (vis_q),
        .reg_wr  (reg_wr),
        .reg_rd  (reg_rd),
        .cm_err  (cm_err),
        .cm_ok   (cm_ok)
    );

    assign gclr   = reg_wr && bus_be[B_GCLR/8]     && bus_wdata[B_GCLR];
    assign en_wr  = reg_wr && bus_be[B_SIG_EN/8];
    assign vis_wr = reg_wr && bus_be[B_VIS/8];

    assign flag_set = {eng_a_illegal, eng_gexc[1], eng_gexc[0]};

    mcs_sticky #(.N(NUM_FLAGS)) i_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (gclr),
        .flags (flags)
    );

    mcs_sigchk i_sigchk (
        .clk      (clk),
        .rst_n    (rst_n),
        .mismatch (sig_mismatch),
        .en_wr    (en_wr),
        .en_val   (bus_wdata[B_SIG_EN]),
        .gclr     (gclr),
        .en_o     (sig_en),
        .flag_o   (sig_flag)
    );

    mcs_vis i_vis (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (vis_wr),
        .val        (bus_wdata[B_VIS]),
        .all_halted (&eng_halted),
        .vis_o      (vis_q),
        .sig_rst_o  (sig_rst)
    );

    always_comb begin
        image                                  = '0;
        image[B_GEXC_A]                        = flags[0];
        image[B_GEXC_B]                        = flags[1];
        image[B_ILL_A]                         = flags[2];
        image[B_SIZE_LO +: SIZE_W]             = SIZE_M1;
        image[B_SIG_FLAG]                      = sig_flag;
        image[B_SIG_EN]                        = sig_en;
        image[B_VIS]                           = vis_q;
    end

    assign bus_rdata    = reg_rd ? image : '0;
    assign bus_err      = cm_err;
    assign cm_access_ok = cm_ok;
    assign vis_o        = vis_q;
    assign eng_cfg_lock = vis_q;

    p_hidden_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_space && !eng_cfg_lock) |-> (bus_err && !cm_access_ok));
    p_partial_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_space && bus_we && (bus_be != 4'hF)) |-> bus_err);
    p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_space && !bus_we) |-> (bus_rdata[31:17] == '0 && bus_rdata[0] == 1'b0));
endmodule

// File: tb/test_mcs_reg.sv
`timescale 1ns/1ps
module test_mcs_reg;
    localparam logic [4:0] SZ = 5'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 0, bus_space = 0, bus_we = 0;
    logic [3:0]  bus_be = 0;
    logic [1:0]  bus_addr_lo = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        bus_err, cm_access_ok;
    logic [1:0]  eng_gexc = 0;
    logic        eng_a_illegal = 0, sig_mismatch = 0;
    logic [1:0]  eng_halted = 0;
    logic        vis_o, eng_cfg_lock, sig_en, sig_rst;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic [2:0] m_flags = 0;
    int         m_chk = 0;   // 0 off, 1 run, 2 fault
    logic       m_vis = 0, m_rst = 0;

    always #2 clk = ~clk;

    mcs_reg #(.SIZE_M1(SZ)) i_mcs_reg (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_image();
        logic [31:0] v = '0;
        v[3:1]  = m_flags;
        v[8:4]  = SZ;
        v[12]   = (m_chk == 2);
        v[13]   = (m_chk == 1);
        v[16]   = m_vis;
        return v;
    endfunction

    function automatic logic m_err(logic rq, logic sp, logic we, logic [3:0] be, logic [1:0] al);
        return rq && sp && (!m_vis || (we && (be != 4'hF || al != 0)));
    endfunction

    task automatic step(logic rq, logic sp, logic we, logic [3:0] be, logic [1:0] al,
                        logic [31:0] wd, logic [1:0] gx, logic il, logic mis, logic [1:0] hl);
        logic wr, clr, enw, visw, e;
        @(negedge clk);
        chk("R9 lock", {31'b0, eng_cfg_lock}, {31'b0, m_vis});
        chk("R6 vis", {31'b0, vis_o}, {31'b0, m_vis});
        chk("R11 en", {31'b0, sig_en}, {31'b0, m_chk == 1});
        chk("R10 rst", {31'b0, sig_rst}, {31'b0, m_rst});
        bus_req = rq; bus_space = sp; bus_we = we; bus_be = be; bus_addr_lo = al;
        bus_wdata = wd; eng_gexc = gx; eng_a_illegal = il; sig_mismatch = mis; eng_halted = hl;
        #1;
        e = m_err(rq, sp, we, be, al);
        chk(m_vis ? "R8 err" : "R7 err", {31'b0, bus_err}, {31'b0, e});
        chk("R8 ok", {31'b0, cm_access_ok}, {31'b0, rq && sp && !e});
        if (rq && !sp && !we) chk("R2 R3 R5 R12 read", bus_rdata, m_image());
        // model next state
        wr   = rq && !sp && we;
        clr  = wr && be[0] && wd[0];
        enw  = wr && be[1];
        visw = wr && be[2] && (hl == 2'b11);
        for (int i = 0; i < 3; i++) begin
            logic s = (i == 0) ? gx[0] : (i == 1) ? gx[1] : il;
            m_flags[i] = s | (m_flags[i] & ~clr);
        end
        if (m_chk == 1 && mis) m_chk = 2;
        else if (enw && wd[13]) m_chk = 1;
        else if (enw && !wd[13] && m_chk == 1) m_chk = 0;
        else if (m_chk == 2 && clr) m_chk = 0;
        m_rst = visw && wd[16];
        if (visw) m_vis = wd[16];
    endtask

    task automatic rd();
        step(1, 0, 0, 4'h0, 0, 0, 0, 0, 0, 2'b00);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state and read
        rd();
        chk("R1 reset image", bus_rdata, {23'b0, SZ, 4'b0});
        // R7: code memory hidden
        step(1, 1, 0, 4'hF, 0, 0, 0, 0, 0, 2'b11);
        // R2 set flags, then R4 set and clear same cycle
        step(0, 0, 0, 0, 0, 0, 2'b01, 0, 0, 0);
        rd();
        chk("R2 flag A", bus_rdata[1], 1);
        step(1, 0, 1, 4'h1, 0, 32'h1, 2'b10, 0, 0, 0);
        rd();
        chk("R4 set wins", bus_rdata[3:1], 3'b010);
        // R3 clear
        step(1, 0, 1, 4'h1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd();
        chk("R3 cleared", bus_rdata[3:0], 0);
        // R12 strobe clear: clear without strobe 0 does nothing
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        step(1, 0, 1, 4'hE, 0, 32'h1, 0, 0, 0, 0);
        rd();
        chk("R12 strobe", bus_rdata[3], 1);
        // R11 mismatch while off ignored
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        rd();
        chk("R11 idle mismatch", bus_rdata[12], 0);
        // R11 enable then mismatch; R13 mismatch with enable write
        step(1, 0, 1, 4'h2, 0, 32'h2000, 0, 0, 0, 0);
        step(1, 0, 1, 4'h2, 0, 32'h2000, 0, 0, 1, 0);
        rd();
        chk("R13 mismatch wins", bus_rdata[13:12], 2'b01);
        // R6 vis locked when one engine running
        step(1, 0, 1, 4'h4, 0, 32'h1_0000, 0, 0, 0, 2'b01);
        rd();
        chk("R6 locked", bus_rdata[16], 0);
        // R10 vis write accepted, checker re-enabled before
        step(1, 0, 1, 4'h2, 0, 32'h2000, 0, 0, 0, 0);
        step(1, 0, 1, 4'h4, 0, 32'h1_0000, 0, 0, 0, 2'b11);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8 partial / misaligned / full
        step(1, 1, 1, 4'h3, 0, 0, 0, 0, 0, 0);
        step(1, 1, 1, 4'hF, 2'd2, 0, 0, 0, 0, 0);
        step(1, 1, 1, 4'hF, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 4'h1, 2'd1, 0, 0, 0, 0, 0);
        // R5 size write ignored
        step(1, 0, 1, 4'hF, 0, 32'h0001_21F0, 0, 0, 0, 0);
        rd();
        chk("R5 size", bus_rdata[8:4], SZ);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] wd = $urandom;
            logic [3:0]  be = ($urandom % 2) ? 4'hF : 4'($urandom);
            logic [1:0]  al = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
            logic [1:0]  hl = ($urandom % 2) ? 2'b11 : 2'($urandom);
            logic        rq = ($urandom % 10) < 7;
            step(rq, 1'($urandom), 1'($urandom), be, al, wd,
                 {($urandom % 10) == 0, ($urandom % 10) == 0},
                 ($urandom % 10) == 0, ($urandom % 8) == 0, hl);
        end
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule